// File: doc/BRIEF.md
# PWM Frame Scan Sequencer

This block turns a stored greyscale frame of 10 rows by 14 columns into a stream of on/off words for a serial row loader. Each pixel is held in an 8-bit frame memory that the block reads through a synchronous read port. The block shows brightness by pulse width modulation. Every row is repeated for 32 time slices. In each slice a pixel is lit only while its intensity is strictly greater than the slice index. Brighter pixels therefore stay lit for more slices of the period.

For every (row, slice) pair the sequencer reads the 14 intensities of that row in column order. It forms a word that holds the row number and the 14 column bits, and offers the word to the loader over a valid/ready handshake. The scan steps through slices inside rows, and wraps from the last row back to the first without end. A source select swaps the memory data for seven test switches; each switch drives a pair of neighbouring columns. An enable input lets the scan finish the word it is building and then pause. Filling the frame memory is outside this block.

Top module: `pwm_frame_scanner`

## Requirements
- R1: Each output word places the row number in bits 17:14 and the column bits in bits 13:0, with column c at bit position 13-c; the row field is always in the range 0 to 9.
- R2: Words are produced in the order row 0..9 (outer) and slice 0..31 (inner); after row 9 slice 31 the next word is row 0 slice 0, repeating forever.
- R3: In memory mode the bit for column c is 1 exactly when bits 4:0 of the intensity at (row, c) are strictly greater than the current slice index; bits 7:5 of the intensity have no effect.
- R4: Over the 32 slices of one row, a pixel with low-5-bit value 0, 1, 15 or 31 is lit in exactly 0, 1, 15 or 31 slices, respectively.
- R5: Intensity (row, c) is read from address row*14 + c with `mem_rd_en` high; the read data is taken one cycle after the address, and the address stays below 140 whenever `mem_rd_en` is high.
- R6: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` stays unchanged; every word in the sequence is delivered exactly once, none is dropped or repeated.
- R7: When `src_switch` is 1, the bit for column c equals `switches[c/2]` in every slice, and the row/slice order of R2 still advances.
- R8: While `scan_en` is low, no new word is started; a word already begun is completed and delivered; raising `scan_en` again continues with the next word in the order; after reset the first word is row 0, slice 0.
- R9: During and right after reset, `word_valid` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Allows new words to be started |
| src_switch | input | 1 | 1 selects the test switches as column source, 0 selects the frame memory |
| switches | input | 7 | Test switches, switch k drives columns 2k and 2k+1 |
| mem_rd_en | output | 1 | Frame memory read strobe |
| mem_addr | output | 8 | Frame memory address, row*14 + column |
| mem_rdata | input | 8 | Frame memory read data, valid one cycle after the address |
| word_valid | output | 1 | Output word is available |
| word_ready | input | 1 | Loader accepts the word when high with `word_valid` |
| word_data | output | 18 | Row field and column bits of the output word |

## Verification
The assertions check on every cycle that a stalled word holds still and stays valid, that the row field and the memory address stay in range, and that the slice and row counters wrap at their limits. Only the bench scenarios can show the values that travel through the block. These are the correct column bits for each intensity and slice, the lit-slice counts at 0, 1, 15 and 31, and the masking of the upper intensity bits. They also cover the pairing of switches onto columns, and the full wrap of the scan order with no gap or repeat under random backpressure. The pause and resume on the enable input is also shown only by the bench.

// File: rtl/pwm_scan_pkg.sv
package pwm_scan_pkg;

    localparam int ROWS    = 10;
    localparam int COLS    = 14;
    localparam int SLICES  = 32;
    localparam int PIX_W   = 8;
    localparam int SW_N    = COLS / 2;

    localparam int ROW_W   = $clog2(ROWS);
    localparam int SLICE_W = $clog2(SLICES);
    localparam int ADDR_W  = $clog2(ROWS * COLS);
    localparam int CNT_W   = $clog2(COLS + 1);
    localparam int WORD_W  = ROW_W + COLS;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COLS-1:0]  cols;
    } scan_word_t;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_RUN  = 2'd1,
        GS_FULL = 2'd2
    } gather_state_e;

    // Lit when the level in the low bits strictly exceeds the slice index.
    function automatic logic pixel_on(input logic [PIX_W-1:0] level,
                                      input logic [SLICE_W-1:0] slice);
        return level[SLICE_W-1:0] > slice;
    endfunction

endpackage

// File: rtl/pwm_scan_counters.sv
module pwm_scan_counters
    import pwm_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               advance,
    output logic [ROW_W-1:0]   row,
    output logic [SLICE_W-1:0] slice
);

    localparam logic [SLICE_W-1:0] SLICE_LAST = SLICE_W'(SLICES - 1);
    localparam logic [ROW_W-1:0]   ROW_LAST   = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            row   <= '0;
            slice <= '0;
        end else if (advance) begin
            if (slice == SLICE_LAST) begin
                slice <= '0;
                row   <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end else begin
                slice <= slice + 1'b1;
            end
        end
    end

    AST_SLICE_WRAP: assert property (@(posedge clk) disable iff (rst)
        advance && slice == SLICE_LAST |=> slice == '0); // R2

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        advance && slice == SLICE_LAST && row == ROW_LAST |=> row == '0); // R2

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        row <= ROW_LAST); // R1

endmodule

// File: rtl/pwm_column_gather.sv
module pwm_column_gather
    import pwm_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic               take,
    input  logic [ROW_W-1:0]   row,
    input  logic [SLICE_W-1:0] slice,
    input  logic               src_switch,
    input  logic [SW_N-1:0]    switches,
    input  logic [PIX_W-1:0]   mem_rdata,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               full,
    output logic [COLS-1:0]    cols
);

    gather_state_e    state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap_col;
    logic [CNT_W-1:0] bit_pos;
    logic             cap_bit;
    logic [COLS-1:0]  acc;

    // Column whose read data is on mem_rdata this cycle (issued one cycle earlier).
    assign cap_col = cnt - 1'b1;
    assign bit_pos = CNT_W'(COLS - 1) - cap_col;
    assign cap_bit = src_switch ? switches[cap_col[CNT_W-1:1]]
                                : pixel_on(mem_rdata, slice);

    assign mem_rd_en = (state == GS_RUN) && (cnt < CNT_W'(COLS));
    assign mem_addr  = mem_rd_en ? ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(cnt)
                                 : '0;
    assign full      = (state == GS_FULL);
    assign cols      = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GS_IDLE;
            cnt   <= '0;
            acc   <= '0;
        end else begin
            unique case (state)
                GS_IDLE: begin
                    if (go) begin
                        state <= GS_RUN;
                        cnt   <= '0;
                    end
                end
                GS_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt != '0) begin
                        acc[bit_pos] <= cap_bit;
                    end
                    if (cnt == CNT_W'(COLS)) begin
                        state <= GS_FULL;
                    end
                end
                GS_FULL: begin
                    if (take) begin
                        state <= go ? GS_RUN : GS_IDLE;
                        cnt   <= '0;
                    end
                end
                default: state <= GS_IDLE;
            endcase
        end
    end

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> mem_addr < ADDR_W'(ROWS * COLS)); // R5

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        full |-> !mem_rd_en); // R5

endmodule

// File: rtl/pwm_word_port.sv
module pwm_word_port
    import pwm_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  scan_word_t word_in,
    input  logic       ready,
    output logic       valid,
    output scan_word_t word_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            word_q <= '0;
        end else if (load) begin
            valid  <= 1'b1;
            word_q <= word_in;
        end else if (valid && ready) begin
            valid  <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(word_q)); // R6

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        load |-> !valid); // R6

endmodule

// File: rtl/pwm_frame_scanner.sv
module pwm_frame_scanner
    import pwm_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              src_switch,
    input  logic [SW_N-1:0]   switches,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [WORD_W-1:0] word_data
);

    logic [ROW_W-1:0]   row;
    logic [SLICE_W-1:0] slice;
    logic               gather_full;
    logic [COLS-1:0]    gather_cols;
    logic               take;
    scan_word_t         next_word;
    scan_word_t         out_word;

    // A gathered word moves to the send register only once it is empty.
    assign take      = gather_full && !word_valid;
    assign next_word = '{row: row, cols: gather_cols};
    assign word_data = out_word;

    pwm_scan_counters u_counters (
        .clk     (clk),
        .rst     (rst),
        .advance (take),
        .row     (row),
        .slice   (slice)
    );

    pwm_column_gather u_gather (
        .clk        (clk),
        .rst        (rst),
        .go         (scan_en),
        .take       (take),
        .row        (row),
        .slice      (slice),
        .src_switch (src_switch),
        .switches   (switches),
        .mem_rdata  (mem_rdata),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .full       (gather_full),
        .cols       (gather_cols)
    );

    pwm_word_port u_port (
        .clk     (clk),
        .rst     (rst),
        .load    (take),
        .word_in (next_word),
        .ready   (word_ready),
        .valid   (word_valid),
        .word_q  (out_word)
    );

    AST_ROW_FIELD: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> out_word.row < ROW_W'(ROWS)); // R1

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !scan_en && !gather_full && !mem_rd_en |=> !mem_rd_en); // R8

endmodule

// File: tb/pwm_frame_scanner_bench.sv
module pwm_frame_scanner_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_en = 1'b0;
    logic        src_switch = 1'b0;
    logic [6:0]  switches = '0;
    logic        mem_rd_en;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        word_valid;
    logic        word_ready = 1'b0;
    logic [17:0] word_data;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  fmem [140];
    logic [15:0] lfsr = 16'hACE1;
    bit          held_valid = 1'b0;
    logic [17:0] held_data = '0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= fmem[mem_addr];
    end

    pwm_frame_scanner u_pwm_frame_scanner (
        .clk        (clk),
        .rst        (rst),
        .scan_en    (scan_en),
        .src_switch (src_switch),
        .switches   (switches),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .word_data  (word_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected word for sequence position k (R1, R2, R3, R7).
    function automatic logic [17:0] exp_word(input int k, input bit sw_mode,
                                             input logic [6:0] sw);
        int r;
        int s;
        logic [17:0] w;
        r = (k / 32) % 10;
        s = k % 32;
        w = '0;
        w[17:14] = 4'(r);
        for (int c = 0; c < 14; c++) begin
            if (sw_mode) w[13-c] = sw[c/2];
            else         w[13-c] = (int'(fmem[r*14+c][4:0]) > s);
        end
        return w;
    endfunction

    task automatic do_reset();
        scan_en    = 1'b0;
        word_ready = 1'b0;
        held_valid = 1'b0;
        rst        = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic recv(output logic [17:0] w, output bit got, input int tmo,
                        input bit stall);
        got = 1'b0;
        w   = '0;
        for (int n = 0; n < tmo; n++) begin
            @(negedge clk);
            if (held_valid)
                check(word_valid && word_data == held_data, "R6 held word changed",
                      32'(word_data), 32'(held_data));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            word_ready = stall ? (lfsr[0] & lfsr[2]) : 1'b1;
            if (word_valid && word_ready) begin
                w = word_data;
                got = 1'b1;
                held_valid = 1'b0;
                @(posedge clk);
                #1 word_ready = 1'b0;
                return;
            end else begin
                held_valid = word_valid;
                held_data  = word_data;
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!word_valid && !mem_rd_en, "R9 outputs during reset",
              {word_valid, mem_rd_en}, 0);
        do_reset();
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (word_valid || mem_rd_en) begin
                check(1'b0, "R8 R9 activity with scan_en low", {word_valid, mem_rd_en}, 0);
                break;
            end
        end
        check(!word_valid, "R8 no word while disabled", word_valid, 0);
    endtask

    task automatic t_full_scan();
        logic [17:0] w;
        bit got;
        for (int a = 0; a < 140; a++) fmem[a] = 8'((a * 37 + 11) ^ (a << 5));
        do_reset();
        scan_en = 1'b1;
        for (int k = 0; k < 330; k++) begin
            recv(w, got, 200, 1'b0);
            check(got && w == exp_word(k, 1'b0, '0), "R1 R2 R3 R5 scan word", w,
                  exp_word(k, 1'b0, '0));
            if (!got) break;
        end
    endtask

    task automatic t_duty();
        logic [17:0] w;
        bit got;
        int lit [6];
        int expn [6];
        expn = '{0, 15, 31, 31, 0, 1};
        for (int j = 0; j < 6; j++) lit[j] = 0;
        for (int a = 0; a < 140; a++) fmem[a] = 8'h10;
        fmem[28] = 8'd0;   fmem[29] = 8'd15; fmem[30] = 8'd31;
        fmem[31] = 8'hFF;  fmem[32] = 8'hE0; fmem[33] = 8'd1;
        do_reset();
        scan_en = 1'b1;
        for (int k = 0; k < 96; k++) begin
            recv(w, got, 200, 1'b0);
            if (!got) break;
            if (w[17:14] == 4'd2)
                for (int j = 0; j < 6; j++) lit[j] += int'(w[13-j]);
        end
        for (int j = 0; j < 6; j++)
            check(lit[j] == expn[j], "R4 R3 lit slice count", lit[j], expn[j]);
    endtask

    task automatic t_backpressure();
        logic [17:0] w;
        bit got;
        for (int a = 0; a < 140; a++) fmem[a] = 8'((a * 13) + 3);
        do_reset();
        scan_en = 1'b1;
        for (int k = 0; k < 80; k++) begin
            recv(w, got, 400, 1'b1);
            check(got && w == exp_word(k, 1'b0, '0), "R6 sequence under stall", w,
                  exp_word(k, 1'b0, '0));
            if (!got) break;
        end
    endtask

    task automatic t_switch();
        logic [17:0] w;
        bit got;
        do_reset();
        src_switch = 1'b1;
        switches   = 7'b1010011;
        scan_en    = 1'b1;
        for (int k = 0; k < 40; k++) begin
            recv(w, got, 200, 1'b0);
            check(got && w == exp_word(k, 1'b1, switches), "R7 switch columns", w,
                  exp_word(k, 1'b1, switches));
            if (!got) break;
        end
        src_switch = 1'b0;
    endtask

    task automatic t_enable();
        logic [17:0] w;
        bit got;
        int k;
        int extra;
        for (int a = 0; a < 140; a++) fmem[a] = 8'(a);
        do_reset();
        scan_en = 1'b1;
        k = 0;
        for (int i = 0; i < 5; i++) begin
            recv(w, got, 200, 1'b0);
            check(got && w == exp_word(k, 1'b0, '0), "R8 first words after reset", w,
                  exp_word(k, 1'b0, '0));
            k++;
        end
        @(negedge clk);
        scan_en = 1'b0;
        extra = 0;
        for (int i = 0; i < 4; i++) begin
            recv(w, got, 60, 1'b0);
            if (!got) break;
            check(w == exp_word(k, 1'b0, '0), "R8 drained word in order", w,
                  exp_word(k, 1'b0, '0));
            k++;
            extra++;
        end
        check(extra <= 2, "R8 words after disable", extra, 2);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (word_valid) break;
        end
        check(!word_valid, "R8 paused output", word_valid, 0);
        scan_en = 1'b1;
        recv(w, got, 200, 1'b0);
        check(got && w == exp_word(k, 1'b0, '0), "R8 resume continues", w,
              exp_word(k, 1'b0, '0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 140; a++) fmem[a] = '0;
        t_reset();
        t_full_scan();
        t_duty();
        t_backpressure();
        t_switch();
        t_enable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule